// File: doc/BRIEF.md
# Posted Store Buffer with Fence Marking

This block sits between a core's store port and a coherent data cache. A store to a line the cache does not yet own is parked in a small FIFO, and an ownership request goes out in the same cycle, so the core keeps running while other caches invalidate their copies. A store to an owned line normally writes the cache in the same cycle. Each parked entry waits for the acknowledgement that names its slot. Entries then leave for the cache one per cycle, oldest first.

Loads present an address and get a same-cycle answer: a hit flag and the newest parked value for that exact address. If there is no hit, the core reads the cache as usual. A fence pulse tags every entry present at that moment. While any tagged entry remains, each new store is parked behind it, even when its line is owned. A busy flag stays high until the last tagged entry has reached the cache.

The cache ownership lookup and the coherence traffic sit outside the block. The store port offers a line-owned flag for the address it presents, and the block talks to the cache through a request, acknowledge and write interface. The depth must be a power of two, at least 2.

Top module: `psb_top`

## Requirements
- R1: After reset the buffer is empty. `fence_busy`, `cw_valid`, `ld_hit` and `own_req_valid` are 0, and `st_ready` is 1.
- R2: A store whose line is not owned (`st_line_owned`=0) is accepted into the buffer in the cycle it is presented while the buffer has room. In that same cycle `own_req_valid` is 1, with `own_req_addr` equal to the store address and `own_req_tag` naming the slot that was used. The cache is not written.
- R3: An owned store is written to the cache in the same cycle (`cw_valid`=1 with the store's address and data) when four things hold: no tagged entry exists, no live entry shares its line, no fence arrives in that cycle and no drain takes place. It is accepted even when the buffer is full.
- R4: `ld_hit` is 1 in the same cycle when a live entry holds exactly `ld_addr`. `ld_data` is then the data of the youngest such entry. With no match, `ld_hit` is 0.
- R5: A fence pulse tags every live entry. `fence_busy` rises in the next cycle if any tagged entry is still live. It falls in the cycle after the cache write of the last tagged entry. A fence on an empty buffer leaves `fence_busy` at 0.
- R6: While any tagged entry is live, an owned store is parked rather than written to the cache, and it issues no ownership request.
- R7: An entry is written to the cache only after an acknowledgement carrying its slot tag (`own_ack_valid`=1, `own_ack_tag`). If it is the oldest entry, the write appears in the cycle after the acknowledgement.
- R8: Entries reach the cache strictly oldest first, one per cycle. An acknowledged younger entry waits while an older one is still unacknowledged.
- R9: When the buffer is full, a store that must be parked sees `st_ready`=0 and is not taken.
- R10: An owned store whose line (address bits above the low `LINE_W` bits) matches a live entry is parked without an ownership request, so it stays in order behind that entry.
- R11: The cache has one write port. An owned store that would write the cache directly is held (`st_ready`=0) in a cycle in which an entry drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store presented |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_line_owned | input | 1 | Cache holds the store's line in an owned state |
| st_ready | output | 1 | Store taken this cycle |
| ld_addr | input | ADDR_W | Load word address |
| ld_hit | output | 1 | A parked entry matches the load |
| ld_data | output | DATA_W | Youngest matching parked data |
| fence | input | 1 | Full-fence pulse |
| fence_busy | output | 1 | Tagged entries still live |
| own_req_valid | output | 1 | Ownership request issued |
| own_req_addr | output | ADDR_W | Address being claimed |
| own_req_tag | output | PTR_W | Slot to be named in the acknowledgement |
| own_ack_valid | input | 1 | All invalidations done for one slot |
| own_ack_tag | input | PTR_W | Slot acknowledged |
| cw_valid | output | 1 | Cache write this cycle |
| cw_addr | output | ADDR_W | Cache write address |
| cw_data | output | DATA_W | Cache write data |

## Verification
The store decision, the ownership request, a direct cache write and the load lookup are all combinational, so they are due in the cycle the stimulus is presented. The bench drives inputs just after the falling edge and samples 1 ns later, before the rising edge. An acknowledgement or a fence only takes effect in state at the next rising edge. The resulting drain or `fence_busy` change is therefore checked one full cycle after the stimulus cycle, and then every cycle after that, to confirm the oldest-first sequence.

// File: rtl/psb_pkg.sv
package psb_pkg;

    typedef struct packed {
        logic live;
        logic owned;
        logic marked;
    } slot_t;

    function automatic logic same_line(input logic [63:0] a, input logic [63:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/psb_slots.sv
module psb_slots
    import psb_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    input  logic              push_owned,
    input  logic              pop,
    input  logic              mark_all,
    input  logic              ack_valid,
    input  logic [PTR_W-1:0]  ack_tag,
    output slot_t             flags  [DEPTH],
    output logic [ADDR_W-1:0] addr_q [DEPTH],
    output logic [DATA_W-1:0] data_q [DEPTH],
    output logic [PTR_W-1:0]  head,
    output logic [PTR_W-1:0]  tail,
    output logic [CNT_W-1:0]  count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) flags[i] <= '0;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (mark_all && flags[i].live) flags[i].marked <= 1'b1;
                if (ack_valid && ack_tag == PTR_W'(i) && flags[i].live) flags[i].owned <= 1'b1;
            end
            if (pop) flags[head] <= '0;
            if (push) begin
                flags[tail]  <= '{live: 1'b1, owned: push_owned, marked: 1'b0};
                addr_q[tail] <= push_addr;
                data_q[tail] <= push_data;
            end
            head  <= pop  ? head + 1'b1 : head;
            tail  <= push ? tail + 1'b1 : tail;
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CNT_W'(DEPTH))); // R9

    AST_ACK_TAKES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && flags[ack_tag].live && !(pop && head == ack_tag))
        |=> flags[$past(ack_tag)].owned); // R7

endmodule

// File: rtl/psb_lookup.sv
module psb_lookup
    import psb_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINE_W = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int TAG_W = ADDR_W - LINE_W
) (
    input  logic [DEPTH-1:0]  live,
    input  logic [ADDR_W-1:0] addr_q [DEPTH],
    input  logic [DATA_W-1:0] data_q [DEPTH],
    input  logic [PTR_W-1:0]  head,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [TAG_W-1:0]  st_line,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic              line_hit
);

    logic [PTR_W-1:0] slot;

    always_comb begin
        ld_hit   = 1'b0;
        ld_data  = '0;
        line_hit = 1'b0;
        slot     = '0;
        // walk oldest to youngest so the last match wins
        for (int i = 0; i < DEPTH; i++) begin
            slot = head + PTR_W'(i);
            if (live[slot]) begin
                if (addr_q[slot] == ld_addr) begin
                    ld_hit  = 1'b1;
                    ld_data = data_q[slot];
                end
                if (same_line(64'(addr_q[slot][ADDR_W-1:LINE_W]), 64'(st_line)))
                    line_hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/psb_top.sv
module psb_top
    import psb_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINE_W = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              st_line_owned,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    input  logic              fence,
    output logic              fence_busy,
    output logic              own_req_valid,
    output logic [ADDR_W-1:0] own_req_addr,
    output logic [PTR_W-1:0]  own_req_tag,
    input  logic              own_ack_valid,
    input  logic [PTR_W-1:0]  own_ack_tag,
    output logic              cw_valid,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [DATA_W-1:0] cw_data
);

    slot_t             flags  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  head, tail;
    logic [CNT_W-1:0]  count;
    logic [DEPTH-1:0]  live_vec, mark_vec;
    logic              line_hit, any_marked, full, drain, must_park, accept, push, direct;

    for (genvar g = 0; g < DEPTH; g++) begin : g_vec
        assign live_vec[g] = flags[g].live;
        assign mark_vec[g] = flags[g].live && flags[g].marked;
    end

    assign any_marked = |mark_vec;
    assign full       = (count == CNT_W'(DEPTH));
    assign drain      = flags[head].live && flags[head].owned;
    assign must_park  = !st_line_owned || any_marked || (fence && count != '0) || line_hit;
    assign st_ready   = must_park ? !full : !drain;
    assign accept     = st_valid && st_ready;
    assign push       = accept && must_park;
    assign direct     = accept && !must_park;

    assign own_req_valid = push && !st_line_owned;
    assign own_req_addr  = st_addr;
    assign own_req_tag   = tail;

    assign cw_valid = drain || direct;
    assign cw_addr  = drain ? addr_q[head] : st_addr;
    assign cw_data  = drain ? data_q[head] : st_data;

    assign fence_busy = any_marked;

    psb_slots #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_addr  (st_addr),
        .push_data  (st_data),
        .push_owned (st_line_owned),
        .pop        (drain),
        .mark_all   (fence),
        .ack_valid  (own_ack_valid),
        .ack_tag    (own_ack_tag),
        .flags      (flags),
        .addr_q     (addr_q),
        .data_q     (data_q),
        .head       (head),
        .tail       (tail),
        .count      (count)
    );

    psb_lookup #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_lookup (
        .live     (live_vec),
        .addr_q   (addr_q),
        .data_q   (data_q),
        .head     (head),
        .ld_addr  (ld_addr),
        .st_line  (st_addr[ADDR_W-1:LINE_W]),
        .ld_hit   (ld_hit),
        .ld_data  (ld_data),
        .line_hit (line_hit)
    );

    AST_BUSY_AFTER_FENCE: assert property (@(posedge clk) disable iff (rst)
        (fence && (count > CNT_W'(1) || (count == CNT_W'(1) && !drain))) |=> fence_busy); // R5

    AST_REQ_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
        own_req_valid |-> !flags[tail].live); // R2

    AST_PARKED_BEHIND_FENCE: assert property (@(posedge clk) disable iff (rst)
        (fence_busy && st_valid && st_ready) |=> (count != '0)); // R6

    AST_ONE_WRITE_PORT: assert property (@(posedge clk) disable iff (rst)
        drain |-> !direct); // R11

endmodule

// File: tb/psb_top_test.sv
`timescale 1ns/1ps
module psb_top_test;
    localparam int DEPTH = 4, ADDR_W = 16, DATA_W = 32, LINE_W = 2;
    localparam int PTR_W = $clog2(DEPTH);

    logic              clk = 1'b0, rst = 1'b1;
    logic              st_valid, st_line_owned, fence, own_ack_valid;
    logic [ADDR_W-1:0] st_addr, ld_addr;
    logic [DATA_W-1:0] st_data;
    logic [PTR_W-1:0]  own_ack_tag;
    logic              st_ready, ld_hit, fence_busy, own_req_valid, cw_valid;
    logic [DATA_W-1:0] ld_data, cw_data;
    logic [ADDR_W-1:0] own_req_addr, cw_addr;
    logic [PTR_W-1:0]  own_req_tag;

    int checks = 0, errors = 0;
    logic [PTR_W-1:0] tag_a, tag_b, tag_c, tag_d;

    always #2.5 clk = ~clk;

    psb_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W)) uut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .st_line_owned(st_line_owned), .st_ready(st_ready), .ld_addr(ld_addr),
        .ld_hit(ld_hit), .ld_data(ld_data), .fence(fence), .fence_busy(fence_busy),
        .own_req_valid(own_req_valid), .own_req_addr(own_req_addr), .own_req_tag(own_req_tag),
        .own_ack_valid(own_ack_valid), .own_ack_tag(own_ack_tag),
        .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data)
    );

    // {addr, data, owned, expect direct write, expect ownership request}
    localparam int VW = ADDR_W + DATA_W + 3;
    localparam logic [VW-1:0] VEC [4] = '{
        {16'h0010, 32'h11, 1'b0, 1'b0, 1'b1},   // R2 not owned: parked, request
        {16'h0020, 32'h22, 1'b1, 1'b1, 1'b0},   // R3 owned, fresh line: direct
        {16'h0011, 32'h33, 1'b1, 1'b0, 1'b0},   // R10 owned, line shared with parked entry
        {16'h0030, 32'h44, 1'b0, 1'b0, 1'b1}    // R2 not owned
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic next();
        @(negedge clk);
        st_valid = 0; st_line_owned = 0; st_addr = '0; st_data = '0;
        ld_addr = '0; fence = 0; own_ack_valid = 0; own_ack_tag = '0;
    endtask

    task automatic store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic own);
        st_valid = 1; st_addr = a; st_data = d; st_line_owned = own;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        next(); rst = 1;
        next(); next();
        rst = 0;
        next(); #1;
        chk("R1 busy", fence_busy, 0);
        chk("R1 cw", cw_valid, 0);
        chk("R1 hit", ld_hit, 0);
        chk("R1 req", own_req_valid, 0);
        chk("R1 ready", st_ready, 1);

        for (int i = 0; i < 4; i++) begin
            next();
            store(VEC[i][VW-1 -: ADDR_W], VEC[i][DATA_W+2:3], VEC[i][2]);
            #1;
            chk("R2/R3/R10 ready", st_ready, 1);
            chk("R2/R3/R10 direct", cw_valid, VEC[i][1]);
            chk("R2/R3/R10 request", own_req_valid, VEC[i][0]);
            if (VEC[i][0]) chk("R2 req addr", own_req_addr, VEC[i][VW-1 -: ADDR_W]);
            if (i == 0) tag_a = own_req_tag;
            if (i == 3) tag_b = own_req_tag;
        end

        next(); ld_addr = 16'h0010; #1;
        chk("R4 hit", ld_hit, 1); chk("R4 data", ld_data, 32'h11);
        next(); ld_addr = 16'h0020; #1;
        chk("R4 miss direct-written", ld_hit, 0);

        next(); store(16'h0010, 32'h55, 0); #1;
        chk("R2 accepted", own_req_valid, 1); chk("R2 no cache write", cw_valid, 0);
        tag_c = own_req_tag;
        next(); ld_addr = 16'h0010; #1;
        chk("R4 youngest", ld_data, 32'h55);

        next(); store(16'h0040, 32'h99, 0); #1;
        chk("R9 full stall", st_ready, 0);
        chk("R9 no request", own_req_valid, 0);
        next(); store(16'h0080, 32'h77, 1); #1;
        chk("R3 direct when full", cw_valid, 1); chk("R3 addr", cw_addr, 16'h0080);

        next(); fence = 1; #1;
        chk("R5 not yet busy", fence_busy, 0);
        next(); #1;
        chk("R5 busy", fence_busy, 1);
        next(); store(16'h0100, 32'h66, 1); #1;
        chk("R6/R9 owned store held", st_ready, 0); chk("R6 no write", cw_valid, 0);

        next(); own_ack_valid = 1; own_ack_tag = tag_b;
        next(); #1;
        chk("R8 younger waits", cw_valid, 0);
        own_ack_valid = 1; own_ack_tag = tag_a;
        next(); #1;
        chk("R7 drain", cw_valid, 1); chk("R7 addr", cw_addr, 16'h0010); chk("R7 data", cw_data, 32'h11);
        next(); #1;
        chk("R8 second", cw_addr, 16'h0011); chk("R8 second data", cw_data, 32'h33);
        next(); #1;
        chk("R8 third", cw_addr, 16'h0030); chk("R8 third data", cw_data, 32'h44);
        next(); store(16'h0100, 32'h66, 1); #1;
        chk("R7 unacked head waits", cw_valid, 0);
        chk("R5 still busy", fence_busy, 1);
        chk("R6 parked ready", st_ready, 1);
        chk("R6 no request", own_req_valid, 0);
        next(); ld_addr = 16'h0100; own_ack_valid = 1; own_ack_tag = tag_c; #1;
        chk("R6 parked not written", ld_hit, 1);
        next(); #1;
        chk("R7 tagged drains", cw_addr, 16'h0010); chk("R7 tagged data", cw_data, 32'h55);
        chk("R5 busy during drain", fence_busy, 1);
        next(); #1;
        chk("R6 follower drains", cw_addr, 16'h0100); chk("R5 busy falls", fence_busy, 0);
        next(); ld_addr = 16'h0010; #1;
        chk("R4 empty miss", ld_hit, 0); chk("R8 idle", cw_valid, 0);

        next(); store(16'h0200, 32'h88, 0); #1;
        tag_d = own_req_tag;
        next(); own_ack_valid = 1; own_ack_tag = tag_d;
        next(); store(16'h0300, 32'h99, 1); #1;
        chk("R11 held during drain", st_ready, 0); chk("R11 drain addr", cw_addr, 16'h0200);
        next(); store(16'h0300, 32'h99, 1); #1;
        chk("R11 then direct", st_ready, 1); chk("R11 addr", cw_addr, 16'h0300);

        next(); fence = 1;
        next(); #1;
        chk("R5 empty fence", fence_busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule